// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block listens to an SPI bus without driving it. It takes in the serial clock, both data lines and an optional chip-select, and turns the traffic into a stream of event records. Each completed word produces one data record, which holds the controller-to-peripheral word and the peripheral-to-controller word side by side. Each chip-select edge produces its own record, which gives the level before the edge and the level after it.

All four clock polarity and phase settings are supported, and the word length is set at run time. The bus pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are detected in the system clock domain. For that reason the system clock must run at least four times faster than the serial clock.

A free-running cycle counter supplies the time at which the first bit of each word was sampled. A running count of completed words is also provided. The configuration inputs are static and are changed only while reset is held.

Top module: `spi_bus_monitor`

## Requirements
- R1: For the first three system clock cycles after reset is released, no event is reported, whatever the pin levels are. While in reset, `evt_valid` is 0 and `word_count` is 0.
- R2: Bits are sampled on the rising serial-clock edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise. The first bit sampled becomes the most significant bit. Words are right-justified in `evt_mosi` and `evt_miso`, and the unused upper bits are zero.
- R3: A word is complete when the number of sampled bits equals the configured length. That length is `cfg_word_len`, except that 0, or any value above `WORD_MAX`, means `WORD_MAX`. A completed word yields one record with `evt_kind` = 0.
- R4: When `cfg_cs_used` is 1, every change of the synchronized chip-select level yields one record with `evt_kind` = 1. In that record, `evt_cs_old` is the level before the change and `evt_cs_new` is the level after it.
- R5: A chip-select change throws away any partly assembled word. A sampling edge that is detected in the same cycle as a chip-select change is also thrown away.
- R6: When `cfg_cs_used` is 0, the chip-select pin has no effect. It produces no records, it does not break up words, and it never sets the error flag.
- R7: When `cfg_cs_active_low` is 1, chip-select is inactive at level 1; when it is 0, chip-select is inactive at level 0. A data record has `evt_cs_err` = 1 if any of its bits was sampled while chip-select was in use and inactive. Chip-select records always carry `evt_cs_err` = 0.
- R8: `evt_start_ts` of a data record is the number of system clock cycles from reset release to the cycle in which the word's first sampling edge was detected. For a chip-select record, it is the cycle in which the change was detected.
- R9: `word_count` goes up by exactly one with each data record. It does not change at any other time.
- R10: Each event is signalled by `evt_valid` being high for a single cycle. The bench model states the exact cycle: an edge on a pin is detected three clock edges after the pin changes, and the record appears one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| cfg_cs_used | input | 1 | 1 when a chip-select line is connected |
| cfg_cs_active_low | input | 1 | 1: chip-select is active low |
| cfg_word_len | input | LEN_W | Word length in bits (0 means WORD_MAX) |
| spi_sck | input | 1 | Serial clock pin |
| spi_mosi | input | 1 | Controller-to-peripheral data pin |
| spi_miso | input | 1 | Peripheral-to-controller data pin |
| spi_cs | input | 1 | Chip-select pin |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_kind | output | 1 | 0: data word, 1: chip-select change |
| evt_mosi | output | WORD_MAX | Controller-to-peripheral word |
| evt_miso | output | WORD_MAX | Peripheral-to-controller word |
| evt_cs_old | output | 1 | Chip-select level before the change |
| evt_cs_new | output | 1 | Chip-select level after the change |
| evt_cs_err | output | 1 | A bit of the word was sampled while chip-select was inactive |
| evt_start_ts | output | TS_W | Start time of the event |
| word_count | output | CNT_W | Number of data words completed |

## Verification
The same byte is sent in all four clock modes. With a wrong edge choice, the captured word comes out shifted by one bit or wrong altogether. Words of lengths 1, 5, 8, 12 and 32 (the last set through the zero encoding) show whether framing follows the configured length. A few bits are sent, then chip-select is toggled, then a full word is sent: only the full word may be reported. Words are sent under both chip-select polarities, with chip-select active and with it inactive, and a run with chip-select unused toggles the pin in the middle of a word. Together these separate error flagging, event emission and framing by bit count alone.

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor #(
  parameter int WORD_MAX = 32,
  parameter int TS_W     = 32,
  parameter int CNT_W    = 16,
  localparam int LEN_W   = $clog2(WORD_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_cs_used,
  input  logic                cfg_cs_active_low,
  input  logic [LEN_W-1:0]    cfg_word_len,
  input  logic                spi_sck,
  input  logic                spi_mosi,
  input  logic                spi_miso,
  input  logic                spi_cs,
  output logic                evt_valid,
  output logic                evt_kind,
  output logic [WORD_MAX-1:0] evt_mosi,
  output logic [WORD_MAX-1:0] evt_miso,
  output logic                evt_cs_old,
  output logic                evt_cs_new,
  output logic                evt_cs_err,
  output logic [TS_W-1:0]     evt_start_ts,
  output logic [CNT_W-1:0]    word_count
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(WORD_MAX);

  // pins ordered {sck, mosi, miso, cs}
  logic [3:0] sy1, sy2, prv;
  logic [1:0] warm;
  logic [TS_W-1:0] ts, ts_first;
  logic [LEN_W-1:0] bitcnt;
  logic [WORD_MAX-1:0] sh_mosi, sh_miso;
  logic err_acc;

  wire sck_now = sy2[3];
  wire sck_was = prv[3];
  wire mosi_b  = sy2[2];
  wire miso_b  = sy2[1];
  wire cs_now  = sy2[0];
  wire cs_was  = prv[0];

  wire live    = (warm == 2'd3);
  wire cs_chg  = live && cfg_cs_used && (cs_now != cs_was);
  wire rise    = sck_now && !sck_was;
  wire fall    = !sck_now && sck_was;
  wire smp     = live && !cs_chg && ((cfg_cpol == cfg_cpha) ? rise : fall);
  wire cs_idle = cfg_cs_used && (cfg_cs_active_low ? cs_now : !cs_now);

  wire [LEN_W-1:0] len_eff =
    (cfg_word_len == '0 || cfg_word_len > LEN_MAX) ? LEN_MAX : cfg_word_len;
  wire first = (bitcnt == '0);
  wire last  = (bitcnt == len_eff - LEN_W'(1));

  wire [WORD_MAX-1:0] base_mosi = first ? '0 : sh_mosi;
  wire [WORD_MAX-1:0] base_miso = first ? '0 : sh_miso;
  wire [WORD_MAX-1:0] nxt_mosi  = {base_mosi[WORD_MAX-2:0], mosi_b};
  wire [WORD_MAX-1:0] nxt_miso  = {base_miso[WORD_MAX-2:0], miso_b};
  wire                nxt_err   = (first ? 1'b0 : err_acc) | cs_idle;
  wire [TS_W-1:0]     nxt_ts    = first ? ts : ts_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
      warm <= '0;
      ts <= '0;
    end else begin
      sy1 <= {spi_sck, spi_mosi, spi_miso, spi_cs};
      sy2 <= sy1;
      prv <= sy2;
      if (!live) warm <= warm + 2'd1;
      ts <= ts + TS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt <= '0;
      sh_mosi <= '0;
      sh_miso <= '0;
      err_acc <= 1'b0;
      ts_first <= '0;
      evt_valid <= 1'b0;
      evt_kind <= 1'b0;
      evt_mosi <= '0;
      evt_miso <= '0;
      evt_cs_old <= 1'b0;
      evt_cs_new <= 1'b0;
      evt_cs_err <= 1'b0;
      evt_start_ts <= '0;
      word_count <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (cs_chg) begin
        evt_valid <= 1'b1;
        evt_kind <= 1'b1;
        evt_cs_old <= cs_was;
        evt_cs_new <= cs_now;
        evt_cs_err <= 1'b0;
        evt_start_ts <= ts;
        bitcnt <= '0;
        sh_mosi <= '0;
        sh_miso <= '0;
        err_acc <= 1'b0;
      end else if (smp) begin
        if (last) begin
          evt_valid <= 1'b1;
          evt_kind <= 1'b0;
          evt_mosi <= nxt_mosi;
          evt_miso <= nxt_miso;
          evt_cs_err <= nxt_err;
          evt_start_ts <= nxt_ts;
          word_count <= word_count + CNT_W'(1);
          bitcnt <= '0;
        end else begin
          bitcnt <= bitcnt + LEN_W'(1);
          sh_mosi <= nxt_mosi;
          sh_miso <= nxt_miso;
          err_acc <= nxt_err;
          ts_first <= nxt_ts;
        end
      end
    end
  end

  assert_quiet_warmup_R1: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd3) |=> !evt_valid);
  assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    bitcnt < len_eff);
  assert_cs_levels_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind) |-> (evt_cs_old != evt_cs_new));
  assert_no_cs_evt_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_cs_used |-> !(evt_valid && (evt_kind || evt_cs_err)));
  assert_cs_evt_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind) |-> !evt_cs_err);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_kind) |-> (word_count == $past(word_count) + CNT_W'(1)));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(evt_valid && !evt_kind) |-> $stable(word_count));
endmodule

// File: tb/test_spi_bus_monitor.sv
`timescale 1ns/1ps
module test_spi_bus_monitor;
  localparam int H = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic c_cpol = 0, c_cpha = 0, c_csu = 1, c_csal = 1;
  logic [5:0] c_len = 6'd8;
  logic sck = 0, mosi = 0, miso = 0, cs = 1;
  logic evt_valid, evt_kind, evt_cs_old, evt_cs_new, evt_cs_err;
  logic [31:0] evt_mosi, evt_miso, evt_start_ts;
  logic [15:0] word_count;

  spi_bus_monitor i_spi_bus_monitor (
    .clk(clk), .rst(rst), .cfg_cpol(c_cpol), .cfg_cpha(c_cpha),
    .cfg_cs_used(c_csu), .cfg_cs_active_low(c_csal), .cfg_word_len(c_len),
    .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_mosi(evt_mosi),
    .evt_miso(evt_miso), .evt_cs_old(evt_cs_old), .evt_cs_new(evt_cs_new),
    .evt_cs_err(evt_cs_err), .evt_start_ts(evt_start_ts), .word_count(word_count));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, stepped once per clock
  logic [3:0] hist[$];
  int n = 0, m_bits = 0, m_count = 0, m_start = 0;
  logic [31:0] m_mosi = 0, m_miso = 0;
  bit m_err = 0, primed = 0;
  bit e_valid = 0, e_kind = 0, e_old = 0, e_new = 0, e_err = 0;
  logic [31:0] e_mosi = 0, e_miso = 0, e_ts = 0;

  always @(posedge clk) begin
    int L;
    logic [3:0] a, b;
    bit edge_ok;
    primed = 1;
    e_valid = 0;
    if (rst) begin
      hist.delete(); n = 0; m_bits = 0; m_count = 0; m_err = 0;
      m_mosi = 0; m_miso = 0;
    end else begin
      L = (c_len == 0 || c_len > 32) ? 32 : int'(c_len);
      hist.push_back({sck, mosi, miso, cs});
      if (hist.size() > 4) void'(hist.pop_front());
      if (hist.size() == 4) begin
        a = hist[1]; b = hist[0];
        edge_ok = (c_cpol == c_cpha) ? (a[3] && !b[3]) : (!a[3] && b[3]);
        if (c_csu && a[0] != b[0]) begin
          e_valid = 1; e_kind = 1; e_old = b[0]; e_new = a[0]; e_err = 0; e_ts = n;
          m_bits = 0; m_mosi = 0; m_miso = 0; m_err = 0;
        end else if (edge_ok) begin
          if (m_bits == 0) begin m_start = n; m_mosi = 0; m_miso = 0; m_err = 0; end
          m_mosi = (m_mosi << 1) | 32'(a[2]);
          m_miso = (m_miso << 1) | 32'(a[1]);
          if (c_csu && (c_csal ? a[0] : !a[0])) m_err = 1;
          m_bits++;
          if (m_bits == L) begin
            e_valid = 1; e_kind = 0; e_mosi = m_mosi; e_miso = m_miso;
            e_err = m_err; e_ts = m_start; m_count++; m_bits = 0;
          end
        end
      end
      n++;
    end
  end

  logic [31:0] last_mo = 0, last_mi = 0;
  bit last_err = 0;
  int ncs = 0;

  always @(negedge clk) begin
    if (primed) begin
      chk(evt_valid == e_valid, "R10 evt_valid", evt_valid, e_valid);
      chk(word_count == 16'(m_count), "R9 word_count", word_count, 16'(m_count));
      if (evt_valid && e_valid) begin
        chk(evt_kind == e_kind, "R3 evt_kind", evt_kind, e_kind);
        chk(evt_start_ts == e_ts, "R8 evt_start_ts", evt_start_ts, e_ts);
        if (e_kind) begin
          chk({evt_cs_old, evt_cs_new} == {e_old, e_new}, "R4 cs levels",
              {evt_cs_old, evt_cs_new}, {e_old, e_new});
        end else begin
          chk(evt_mosi == e_mosi, "R2 evt_mosi", evt_mosi, e_mosi);
          chk(evt_miso == e_miso, "R2 evt_miso", evt_miso, e_miso);
        end
        chk(evt_cs_err == e_err, "R7 evt_cs_err", evt_cs_err, e_err);
      end
      if (evt_valid) begin
        if (evt_kind) ncs++;
        else begin last_mo = evt_mosi; last_mi = evt_miso; last_err = evt_cs_err; end
      end
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset(input bit p, input bit h, input bit u, input bit al, input logic [5:0] len);
    rst = 1;
    c_cpol = p; c_cpha = h; c_csu = u; c_csal = al; c_len = len;
    sck = p; cs = al; mosi = 0; miso = 0;
    cyc(4);
    chk(evt_valid == 0 && word_count == 0, "R1 reset state", {evt_valid, word_count}, 0);
    rst = 0;
    ncs = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk(evt_valid == 0, "R1 quiet after reset", evt_valid, 0);
    end
  endtask

  task automatic xfer(input int len, input logic [31:0] mo, input logic [31:0] mi);
    for (int i = len - 1; i >= 0; i--) begin
      if (!c_cpha) begin
        mosi = mo[i]; miso = mi[i]; cyc(H);
        sck = ~c_cpol; cyc(H);
        sck = c_cpol;
      end else begin
        sck = ~c_cpol; mosi = mo[i]; miso = mi[i]; cyc(H);
        sck = c_cpol; cyc(H);
      end
    end
    cyc(H);
  endtask

  task automatic final_report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    final_report();
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(m[1], m[0], 1, 1, 6'd8);
      cs = 0; cyc(6);
      xfer(8, 32'hA5, 32'h3C);
      cs = 1; cyc(10);
      chk(last_mo == 32'hA5, "R2 mode mosi", last_mo, 32'hA5);
      chk(last_mi == 32'h3C, "R2 mode miso", last_mi, 32'h3C);
      chk(ncs == 2, "R4 cs event count", ncs, 2);
      chk(word_count == 1, "R9 one word", word_count, 1);
      chk(last_err == 0, "R7 active word clean", last_err, 0);
    end

    do_reset(0, 0, 1, 1, 6'd5);
    cs = 0; cyc(6);
    xfer(5, 32'h13, 32'h0C);
    xfer(5, 32'h0A, 32'h15);
    cs = 1; cyc(10);
    chk(word_count == 2, "R3 five-bit count", word_count, 2);
    chk(last_mo == 32'h0A && last_mi == 32'h15, "R3 five-bit word", {last_mo, last_mi}, {32'h0A, 32'h15});

    do_reset(1, 0, 1, 1, 6'd12);
    cs = 0; cyc(6);
    xfer(12, 32'hABC, 32'h123);
    cs = 1; cyc(10);
    chk(last_mo == 32'hABC && last_mi == 32'h123, "R3 twelve-bit word", {last_mo, last_mi}, {32'hABC, 32'h123});

    do_reset(0, 1, 1, 1, 6'd0);
    cs = 0; cyc(6);
    xfer(32, 32'hDEADBEEF, 32'h0F1E2D3C);
    cs = 1; cyc(10);
    chk(word_count == 1, "R3 zero means max count", word_count, 1);
    chk(last_mo == 32'hDEADBEEF && last_mi == 32'h0F1E2D3C, "R3 max word",
        {last_mo, last_mi}, {32'hDEADBEEF, 32'h0F1E2D3C});

    do_reset(0, 0, 1, 1, 6'd1);
    cs = 0; cyc(6);
    xfer(4, 32'hB, 32'h4);
    cs = 1; cyc(10);
    chk(word_count == 4, "R3 one-bit words", word_count, 4);
    chk(last_mo == 1 && last_mi == 0, "R3 one-bit last", {last_mo, last_mi}, {32'd1, 32'd0});

    do_reset(0, 0, 1, 1, 6'd8);
    cs = 0; cyc(6);
    xfer(3, 32'h5, 32'h2);
    cs = 1; cyc(6);
    cs = 0; cyc(6);
    xfer(8, 32'h5A, 32'hC3);
    cs = 1; cyc(10);
    chk(word_count == 1, "R5 partial dropped", word_count, 1);
    chk(last_mo == 32'h5A && last_mi == 32'hC3, "R5 clean word", {last_mo, last_mi}, {32'h5A, 32'hC3});
    chk(ncs == 4, "R4 four changes", ncs, 4);

    do_reset(0, 0, 1, 1, 6'd8);
    xfer(8, 32'h11, 32'h22);
    cyc(10);
    chk(last_err == 1, "R7 inactive low-polarity", last_err, 1);
    cs = 0; cyc(6);
    xfer(8, 32'h33, 32'h44);
    cyc(10);
    chk(last_err == 0, "R7 active low-polarity", last_err, 0);

    do_reset(0, 0, 1, 0, 6'd8);
    cs = 1; cyc(6);
    xfer(8, 32'h66, 32'h77);
    cyc(10);
    chk(last_err == 0, "R7 active high-polarity", last_err, 0);
    cs = 0; cyc(6);
    xfer(8, 32'h88, 32'h99);
    cyc(10);
    chk(last_err == 1, "R7 inactive high-polarity", last_err, 1);
    chk(ncs == 2, "R4 high-polarity changes", ncs, 2);

    do_reset(1, 1, 0, 1, 6'd8);
    cs = 0; cyc(6);
    cs = 1; cyc(6);
    cs = 0;
    xfer(4, 32'hA, 32'h5);
    cs = 1; cyc(6);
    xfer(4, 32'h7, 32'h9);
    cyc(10);
    chk(ncs == 0, "R6 no cs events", ncs, 0);
    chk(word_count == 1, "R6 count framing", word_count, 1);
    chk(last_mo == 32'hA7 && last_mi == 32'h59, "R6 word across toggles",
        {last_mo, last_mi}, {32'hA7, 32'h59});
    chk(last_err == 0, "R6 no error flag", last_err, 0);

    final_report();
  end
endmodule